// File: doc/BRIEF.md
# SPI serial memory slave controller

This block is the slave end of a serial-peripheral byte memory of 1K x 8. It oversamples the serial clock, chip select, data input and pause input with the system clock. It frames each transaction on the chip-select edges and shifts in an 8-bit instruction. It then runs one of six commands against a synchronous RAM model: set or clear the write-enable latch, read or write the status byte, and read or write the array. Any other instruction byte leaves the block unchanged for the rest of that transaction.

Data writes and status writes are held until chip select rises. A data write collects bytes in a page buffer. When it is committed, the buffer is written into the array one byte per system clock, inside a fixed busy period. The write-enable latch and two block-protect bits gate these writes. A pause input stops the serial transfer at any point and then resumes it without loss. The serial output comes as a data bit plus a separate enable, so that a pad cell can tri-state it.

Top module: `spimem_slave`

## Requirements
- R1: After reset the output enable is low, the write-enable latch is clear, both protect bits are zero and the device is not busy.
- R2: Input bits are taken on rising SCK and output bits change on falling SCK. Transfers work with SCK idling low (mode 0) and idling high (mode 3).
- R3: so_oe is low whenever cs_n is high, and is high while a read or status byte is being shifted out.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Any opcode outside {0x01,0x02,0x03,0x04,0x05,0x06} has no effect.
- R5: Opcode 0x05 returns the status byte, repeated for as long as cs_n stays low. Bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protect field and bits 7:4 read 0.
- R6: Opcode 0x03 is followed by a 16-bit address, MSB first, of which only the low 10 bits are used. Bytes then stream out MSB first, the address rising by one per byte and wrapping from 1023 to 0.
- R7: Opcode 0x02 with an address and data bytes updates the array only if the write-enable latch was set before the opcode. Otherwise the array is unchanged.
- R8: When cs_n rises with a partial data byte, the write is cancelled: the array is unchanged and the write-enable latch stays set.
- R9: Write data fills an 8-byte page buffer starting at the address column. Bytes past the page end wrap to the start of the same page.
- R10: A committed write clears the write-enable latch and sets the busy bit for BUSY_CYCLES clocks. While busy, every opcode except 0x05 is ignored.
- R11: Opcode 0x01 with one data byte loads the protect field from data bits 3:2 when cs_n rises on a byte boundary with the latch set. It then clears the latch and starts a busy period. With the latch clear it has no effect.
- R12: Protect field 01 blocks writes to addresses 768-1023, 10 blocks 512-1023 and 11 blocks the whole array. A blocked byte keeps its old value.
- R13: With hold_n low, SCK edges are ignored and so_oe is low, and releasing hold_n resumes the transfer where it stopped. A hold_n edge takes effect only while SCK is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select that frames a transaction |
| si | input | 1 | Serial data in: opcode, address, data |
| hold_n | input | 1 | Active-low pause of the serial transfer |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; low means high impedance |

## Verification
The hardest situations to reach are those that depend on exact timing: the busy window after a commit, and a pause that starts and ends mid-byte. The bench makes the busy period long and issues a write-enable, an array read and a status read before it ends. It then checks that only the status read was served. For the pause, a directed read lowers hold_n both while SCK is low and while SCK is high, and toggles SCK during the pause. The streamed byte must come out intact, and so_oe must drop only once the pause has taken effect.

// File: rtl/spimem_pkg.sv
// Shared opcodes, sequencer states and the block-protect decode for the
// serial memory slave. Assumes the protect field is two bits wide.
package spimem_pkg;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_SROUT,
        ST_SRIN,
        ST_IDLE
    } spim_state_e;

    localparam logic [7:0] OP_SET_WEL = 8'h06;
    localparam logic [7:0] OP_CLR_WEL = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [7:0] OP_RD_MEM  = 8'h03;
    localparam logic [7:0] OP_WR_MEM  = 8'h02;

    // True when an address whose top two bits are top2 is read-only under prot.
    function automatic logic is_blocked(input logic [1:0] prot, input logic [1:0] top2);
        case (prot)
            2'b00:   is_blocked = 1'b0;
            2'b01:   is_blocked = (top2 == 2'b11);
            2'b10:   is_blocked = top2[1];
            default: is_blocked = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spimem_sync.sv
// Two-flop synchroniser for a group of asynchronous pins. Every bit gets the
// same latency so that the relative order of the pin edges is preserved.
// Assumes the pins are slow compared with clk.
module spimem_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta;
        // Two register stages per pin, each reset to the pin's idle level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta   <= RST_VAL[g];
                lvl[g] <= RST_VAL[g];
            end else begin
                meta   <= din[g];
                lvl[g] <= meta;
            end
        end
    end
endmodule

// File: rtl/spimem_ram.sv
// Simple dual-port synchronous RAM: one write port and one registered read
// port. The contents are not reset.
module spimem_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [1<<AW];

    // Write on we; read is registered every cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/spimem_slave.sv
// Serial-peripheral memory slave. Oversamples the serial pins with clk,
// decodes an 8-bit opcode and runs the transfer against a 1K x 8 RAM.
// Writes are buffered per page and committed on chip-select rise.
// Assumes: SCK half period of at least 4 clk cycles, PAGE_BYTES a power of
// two of at least 2, and BUSY_CYCLES >= PAGE_BYTES.
module spimem_slave
    import spimem_pkg::*;
#(
    parameter int AW          = 10,
    parameter int PAGE_BYTES  = 8,
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic [3:0]    pins_s;
    logic          sck_s, cs_s, si_s, hold_s;
    logic          sck_d, cs_d;
    logic          held;
    spim_state_e   st;
    logic [3:0]    cnt;
    logic [6:0]    shin;
    logic [7:0]    byte_in;
    logic [AW-1:0] addr, addr_nx, rd_addr;
    logic          is_wr, wel;
    logic [1:0]    bp, sr_pend;
    logic          sr_got;
    logic [PW-1:0] wcol, walk_idx;
    logic          walk_on;
    logic [PAGE_BYTES-1:0] pval;
    logic [7:0]    pbuf [PAGE_BYTES];
    logic [BW-1:0] busy_cnt;
    logic          busy;
    logic [2:0]    ocnt;
    logic [6:0]    tx;
    logic [7:0]    src, ram_q;
    logic          so_q, oe_q;
    logic          cs_r, cs_f, rise, fall, wr_commit, sr_commit;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;

    spimem_sync #(.W(4), .RST_VAL(4'b1010)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({hold_n, si, cs_n, sck}), .lvl(pins_s)
    );
    assign sck_s  = pins_s[0];
    assign cs_s   = pins_s[1];
    assign si_s   = pins_s[2];
    assign hold_s = pins_s[3];

    // Previous levels of SCK and chip select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end

    // The pause state follows hold_n only while SCK is low.
    always_ff @(posedge clk) begin
        if (!rst_n)      held <= 1'b0;
        else if (!sck_s) held <= ~hold_s;
    end

    assign cs_r      = cs_s & ~cs_d;
    assign cs_f      = ~cs_s & cs_d;
    assign rise      = sck_s & ~sck_d & ~cs_s & ~held;
    assign fall      = ~sck_s & sck_d & ~cs_s & ~held;
    assign byte_in   = {shin, si_s};
    assign addr_nx   = {addr[AW-2:0], si_s};
    assign busy      = (busy_cnt != '0);
    assign wr_commit = cs_r && st == ST_WDATA && cnt == 4'd0 && (|pval) && wel;
    assign sr_commit = cs_r && st == ST_SRIN && cnt == 4'd0 && sr_got && wel;
    assign src       = (st == ST_SROUT) ? {4'b0000, bp, wel, busy} : ram_q;

    // Main sequencer: framing, opcode decode, address, data and output shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_OPC;    cnt <= '0;     shin <= '0;    addr <= '0;
            rd_addr <= '0;   is_wr <= 1'b0; wel <= 1'b0;   bp <= '0;
            wcol <= '0;      pval <= '0;    sr_pend <= '0; sr_got <= 1'b0;
            ocnt <= '0;      tx <= '0;      so_q <= 1'b0;  oe_q <= 1'b0;
            walk_on <= 1'b0; walk_idx <= '0;
        end else begin
            if (walk_on) begin
                walk_idx <= walk_idx + 1'b1;
                if (walk_idx == PW'(PAGE_BYTES - 1)) walk_on <= 1'b0;
            end
            if (cs_r) begin
                if (wr_commit) begin
                    wel      <= 1'b0;
                    walk_on  <= 1'b1;
                    walk_idx <= '0;
                end
                if (sr_commit) begin
                    wel <= 1'b0;
                    bp  <= sr_pend;
                end
                st <= ST_OPC; cnt <= '0; oe_q <= 1'b0; ocnt <= '0;
            end else if (cs_f) begin
                st <= ST_OPC; cnt <= '0; oe_q <= 1'b0; ocnt <= '0; sr_got <= 1'b0;
            end else if (rise) begin
                shin <= byte_in[6:0];
                cnt  <= cnt + 1'b1;
                case (st)
                    ST_OPC: if (cnt == 4'd7) begin
                        cnt <= '0;
                        st  <= ST_IDLE;
                        case (byte_in)
                            OP_SET_WEL: if (!busy) wel <= 1'b1;
                            OP_CLR_WEL: if (!busy) wel <= 1'b0;
                            OP_RD_STAT: st <= ST_SROUT;
                            OP_WR_STAT: if (!busy) st <= ST_SRIN;
                            OP_RD_MEM, OP_WR_MEM: if (!busy) begin
                                st    <= ST_ADDR;
                                is_wr <= (byte_in == OP_WR_MEM);
                                if (byte_in == OP_WR_MEM) pval <= '0;
                            end
                            default: ;
                        endcase
                    end
                    ST_ADDR: begin
                        addr <= addr_nx;
                        if (cnt == 4'd15) begin
                            st      <= is_wr ? ST_WDATA : ST_RDATA;
                            rd_addr <= addr_nx;
                            wcol    <= addr_nx[PW-1:0];
                        end
                    end
                    ST_RDATA: if (cnt == 4'd7) begin
                        cnt     <= '0;
                        rd_addr <= rd_addr + 1'b1;
                    end
                    ST_WDATA: if (cnt == 4'd7) begin
                        cnt        <= '0;
                        pval[wcol] <= 1'b1;
                        wcol       <= wcol + 1'b1;
                    end
                    ST_SRIN: if (cnt == 4'd7) begin
                        cnt     <= '0;
                        sr_pend <= byte_in[3:2];
                        sr_got  <= 1'b1;
                    end
                    default: if (cnt == 4'd7) cnt <= '0;
                endcase
            end else if (fall && (st == ST_RDATA || st == ST_SROUT)) begin
                ocnt <= ocnt + 1'b1;
                oe_q <= 1'b1;
                if (ocnt == 3'd0) begin
                    so_q <= src[7];
                    tx   <= src[6:0];
                end else begin
                    so_q <= tx[6];
                    tx   <= {tx[5:0], 1'b0};
                end
            end
        end
    end

    // Page buffer capture, one byte per completed data byte.
    always_ff @(posedge clk) begin
        if (rise && !cs_r && !cs_f && st == ST_WDATA && cnt == 4'd7)
            pbuf[wcol] <= byte_in;
    end

    // Busy period counter, loaded on any commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                      busy_cnt <= '0;
        else if (wr_commit || sr_commit) busy_cnt <= BW'(BUSY_CYCLES);
        else if (busy)                   busy_cnt <= busy_cnt - 1'b1;
    end

    assign ram_waddr = {addr[AW-1:PW], walk_idx};
    assign ram_we    = walk_on & pval[walk_idx] & ~is_blocked(bp, ram_waddr[AW-1:AW-2]);

    spimem_ram #(.AW(AW), .DW(8)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(pbuf[walk_idx]),
        .raddr(rd_addr), .rdata(ram_q)
    );

    assign so    = so_q;
    assign so_oe = oe_q & ~held;
endmodule

// File: rtl/spimem_slave_chk.sv
// Property checker for spimem_slave, attached by bind. It observes the
// synchronised pins and the control state only and drives nothing.
module spimem_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_s,
    input logic       sck_s,
    input logic       held,
    input logic       so_oe,
    input logic       wel,
    input logic       busy,
    input logic [1:0] bp,
    input logic       ram_we
);
    // R3: output stays released while chip select has been high for two cycles.
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_s) && cs_s) |-> !so_oe);

    // R10: the start of a busy period always comes with a cleared latch.
    assert_commit_clears_wel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !wel);

    // R7: the array is only written inside a busy period.
    assert_write_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> busy);

    // R11: the protect field only changes on the cycle a busy period starts.
    assert_bp_on_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp) |-> (busy && !$past(busy)));

    // R13: the pause state only moves while SCK was low.
    assert_hold_sck_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(held) |-> !$past(sck_s));
endmodule

bind spimem_slave spimem_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .held(held),
    .so_oe(so_oe), .wel(wel), .busy(busy), .bp(bp), .ram_we(ram_we)
);

// File: tb/spimem_slave_bench.sv
// Self-checking bench: directed corner cases plus seeded random writes and
// read-backs, compared against a bench-side memory model.
module spimem_slave_bench;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe;
    logic mode3 = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] mdl [1024];
    logic [7:0] wbuf [8];
    logic [1:0] mbp = 2'b00;
    logic       mwel = 1'b0;

    always #2 clk = ~clk;

    spimem_slave #(.AW(10), .PAGE_BYTES(8), .BUSY_CYCLES(800)) u_spimem_slave (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic blocked(input logic [9:0] a, input logic [1:0] p);
        case (p)
            2'b00:   blocked = 1'b0;
            2'b01:   blocked = (a >= 10'd768);
            2'b10:   blocked = (a >= 10'd512);
            default: blocked = 1'b1;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] txb, output logic [7:0] rx, output logic oe_all);
        rx = '0;
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = txb[i]; tick(H);
            rx[i] = so; oe_all &= so_oe;
            sck = 1'b1; tick(H);
        end
    endtask

    task automatic tx_begin();
        sck = mode3; tick(H); cs_n = 1'b0; tick(H);
    endtask

    task automatic tx_end();
        sck = mode3; tick(H); cs_n = 1'b1; tick(H);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r; logic o;
        tx_begin(); xfer(op, r, o); tx_end();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] r; logic o;
        tx_begin(); xfer(8'h05, r, o); xfer(8'h00, st, o); tx_end();
    endtask

    task automatic wait_ready();
        logic [7:0] st;
        for (int k = 0; k < 40; k++) begin
            rdsr(st);
            if (st[0] == 1'b0) break;
        end
    endtask

    // WRITE of n bytes from wbuf, model update, then wait for ready.
    task automatic wr_n(input logic [15:0] a, input int n);
        logic [7:0] r; logic o;
        tx_begin();
        xfer(8'h02, r, o); xfer(a[15:8], r, o); xfer(a[7:0], r, o);
        for (int k = 0; k < n; k++) xfer(wbuf[k], r, o);
        tx_end();
        if (mwel && n > 0) begin
            for (int k = 0; k < n; k++) begin
                logic [9:0] ad;
                ad = {a[9:3], 3'(a[2:0] + k)};
                if (!blocked(ad, mbp)) mdl[ad] = wbuf[k];
            end
            mwel = 1'b0;
        end
        wait_ready();
    endtask

    task automatic wr1(input logic [15:0] a, input logic [7:0] d);
        cmd1(8'h06); mwel = 1'b1;
        wbuf[0] = d; wr_n(a, 1);
    endtask

    task automatic rd_chk(input logic [15:0] a, input int n, input string req);
        logic [7:0] r; logic o;
        tx_begin();
        xfer(8'h03, r, o); xfer(a[15:8], r, o); xfer(a[7:0], r, o);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, r, o);
            chk(req, {24'd0, r}, {24'd0, mdl[10'(a[9:0] + k)]});
            chk("R3 so_oe during read", {31'd0, o}, 32'd1);
        end
        tx_end();
        chk("R3 so_oe after CS high", {31'd0, so_oe}, 32'd0);
    endtask

    task automatic wrsr(input logic [7:0] d);
        logic [7:0] r; logic o;
        tx_begin(); xfer(8'h01, r, o); xfer(d, r, o); tx_end();
        if (mwel) begin mbp = d[3:2]; mwel = 1'b0; end
        wait_ready();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] st, r;
        logic o;
        void'($urandom(32'd20240611));
        tick(5); rst_n = 1'b1; tick(5);

        // R1: reset state
        chk("R1 so_oe after reset", {31'd0, so_oe}, 32'd0);
        rdsr(st);
        chk("R1 R5 status after reset", {24'd0, st}, 32'h00);

        // R4: latch control and unknown opcodes
        cmd1(8'h06); rdsr(st);
        chk("R4 WREN sets latch", {24'd0, st}, 32'h02);
        cmd1(8'hA5); rdsr(st);
        chk("R4 unknown opcode ignored", {24'd0, st}, 32'h02);
        cmd1(8'h04); rdsr(st);
        chk("R4 WRDI clears latch", {24'd0, st}, 32'h00);
        cmd1(8'h07); cmd1(8'h86); rdsr(st);
        chk("R4 near-miss opcodes ignored", {24'd0, st}, 32'h00);

        // R5: status byte repeats while CS stays low
        cmd1(8'h06);
        tx_begin(); xfer(8'h05, r, o); xfer(8'h00, st, o); xfer(8'h00, r, o); tx_end();
        chk("R5 status repeat", {24'd0, r}, 32'h02);
        cmd1(8'h04);

        // R7: write with and without the latch
        wr1(16'h0040, 8'h5A);
        wbuf[0] = 8'h11; wr_n(16'h0040, 1);
        rd_chk(16'h0040, 1, "R7 write needs latch");

        // R2: mode 3 transfers
        mode3 = 1'b1;
        wr1(16'h0123, 8'hC3);
        rd_chk(16'h0123, 1, "R2 mode 3 write/read");
        mode3 = 1'b0;
        rd_chk(16'h0123, 1, "R2 mode 0 read");

        // R6: upper address bits ignored, wrap 1023 -> 0
        wr1(16'h03FF, 8'h9E);
        wr1(16'h0000, 8'h27);
        rd_chk(16'hFFFF, 2, "R6 read wrap");

        // R9: page buffer wraps inside the page
        cmd1(8'h06); mwel = 1'b1;
        for (int k = 0; k < 8; k++) wbuf[k] = 8'(8'h30 + k);
        wr_n(16'h0100, 8);
        cmd1(8'h06); mwel = 1'b1;
        for (int k = 0; k < 4; k++) wbuf[k] = 8'(8'hE0 + k);
        wr_n(16'h0106, 4);
        rd_chk(16'h0100, 8, "R9 page wrap");

        // R8: CS rise mid-byte cancels the write, latch stays set
        cmd1(8'h06);
        tx_begin();
        xfer(8'h02, r, o); xfer(8'h00, r, o); xfer(8'h40, r, o); xfer(8'h77, r, o);
        for (int i = 0; i < 3; i++) begin
            sck = 1'b0; si = 1'b1; tick(H); sck = 1'b1; tick(H);
        end
        tx_end();
        rdsr(st);
        chk("R8 latch kept after cancel", {24'd0, st}, 32'h02);
        rd_chk(16'h0040, 1, "R8 array unchanged after cancel");
        cmd1(8'h04);

        // R10: busy window behaviour
        cmd1(8'h06); mwel = 1'b1;
        wbuf[0] = 8'h6D;
        tx_begin();
        xfer(8'h02, r, o); xfer(8'h02, r, o); xfer(8'h80, r, o); xfer(wbuf[0], r, o);
        tx_end();
        mdl[10'h280] = 8'h6D; mwel = 1'b0;
        cmd1(8'h06);
        tx_begin();
        xfer(8'h03, r, o); xfer(8'h02, r, o); xfer(8'h80, r, o); xfer(8'h00, r, o);
        tx_end();
        chk("R10 read ignored while busy", {31'd0, o}, 32'd0);
        rdsr(st);
        chk("R10 busy set, latch clear", {24'd0, st}, 32'h01);
        wait_ready();
        rdsr(st);
        chk("R10 ready, WREN during busy dropped", {24'd0, st}, 32'h00);
        rd_chk(16'h0280, 1, "R10 committed data");

        // R11: status write with and without the latch
        wrsr(8'h0C); rdsr(st);
        chk("R11 no effect without latch", {24'd0, st}, 32'h00);

        // R12: protection ranges
        wr1(16'h03F0, 8'hA1); wr1(16'h02F0, 8'hA2);
        wr1(16'h0200, 8'hA3); wr1(16'h01F0, 8'hA4);
        cmd1(8'h06); mwel = 1'b1; wrsr(8'h04); rdsr(st);
        chk("R11 protect field loaded", {24'd0, st}, 32'h04);
        wr1(16'h03F0, 8'h00); wr1(16'h02F0, 8'h01);
        rd_chk(16'h03F0, 1, "R12 quarter blocked");
        rd_chk(16'h02F0, 1, "R12 below quarter writable");
        cmd1(8'h06); mwel = 1'b1; wrsr(8'h08);
        wr1(16'h0200, 8'h02); wr1(16'h01F0, 8'h03);
        rd_chk(16'h0200, 1, "R12 half blocked");
        rd_chk(16'h01F0, 1, "R12 below half writable");
        cmd1(8'h06); mwel = 1'b1; wrsr(8'h0C);
        wr1(16'h0000, 8'hFF);
        rd_chk(16'h0000, 1, "R12 whole array blocked");
        cmd1(8'h06); mwel = 1'b1; wrsr(8'h00);

        // R13: pause mid-byte during a read
        tx_begin();
        xfer(8'h03, r, o); xfer(8'h01, r, o); xfer(8'h00, r, o);
        r = '0;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = 1'b0; tick(H);
            if (i == 4) begin
                hold_n = 1'b0; tick(H);
                chk("R13 so_oe low in pause", {31'd0, so_oe}, 32'd0);
                sck = 1'b1; tick(H); sck = 1'b0; tick(H);
                sck = 1'b1; tick(H); sck = 1'b0; tick(H);
                chk("R13 so_oe low after ignored edges", {31'd0, so_oe}, 32'd0);
                hold_n = 1'b1; tick(H);
            end
            if (i == 1) begin
                chk("R13 pause taken once SCK low", {31'd0, so_oe}, 32'd0);
                hold_n = 1'b1; tick(H);
            end
            r[i] = so;
            sck = 1'b1; tick(H);
            if (i == 2) begin
                hold_n = 1'b0; tick(H);
                chk("R13 hold edge with SCK high not taken", {31'd0, so_oe}, 32'd1);
            end
        end
        chk("R13 byte intact across pauses", {24'd0, r}, {24'd0, mdl[10'h100]});
        xfer(8'h00, r, o);
        chk("R13 stream continues", {24'd0, r}, {24'd0, mdl[10'h101]});
        tx_end();

        // R2 R6 R7: seeded random writes and read-backs in both modes
        for (int it = 0; it < 12; it++) begin
            logic [15:0] a;
            int n;
            mode3 = 1'($urandom_range(0, 1));
            a = 16'($urandom);
            n = $urandom_range(1, 8 - int'(a[2:0]));
            cmd1(8'h06); mwel = 1'b1;
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            wr_n(a, n);
            rd_chk(a, n, "R6 R7 random write/read");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule